// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block has two timer/counter channels. Each channel holds a 16-bit count as a high byte and a low byte. One shared mode byte configures both channels. A control byte holds a run bit and an overflow flag for each channel. Software reaches the mode, control and four count bytes through a byte-wide register port. Writes are synchronous and reads are combinational.

A channel advances on the machine-cycle `tick` input or on falling edges of its external count pin. The gate bit in the mode byte can also make counting depend on the channel's gate pin. Four counting modes are available:

- a 13-bit mode with a 5-bit prescaler,
- a plain 16-bit mode,
- an 8-bit auto-reload mode,
- a split mode in which channel 0 becomes two independent 8-bit timers.

The overflow flags drive two output pins, for use by an interrupt controller outside the block.

Top module: `dual_tmr`

## Requirements
- R1: After reset, all six registers read 0x00 and both flag outputs are low.
- R2: Register map, by `reg_addr`: 0 is the mode byte, 1 is the control byte, 2 and 3 are the low and high bytes of channel 0, 4 and 5 are the low and high bytes of channel 1, and 6 and 7 read 0x00. Control byte layout: bit 0 is run0, bit 1 is flag0, bit 2 is run1, bit 3 is flag1.
- R3: Mode byte bits [3:0] configure channel 0 and bits [7:4] configure channel 1. Within each nibble, bit 3 is gate, bit 2 is counter select, and bits 1:0 are the mode code. Mode codes: 00 is 13-bit, 01 is 16-bit, 10 is auto-reload, 11 is split.
- R4: In 16-bit mode, each enabled event adds one to {high,low}. The step from 0xFFFF goes to 0x0000 and sets the channel's flag.
- R5: In 13-bit mode, only low bits [4:0] count and low bits [7:5] are left untouched. The high byte increments when low bits [4:0] pass 31. The step from high 0xFF with low bits [4:0] at 31 clears both fields and sets the flag.
- R6: In auto-reload mode, the low byte counts. On the step from 0xFF it loads the high byte's value and sets the flag. The high byte never changes by itself.
- R7: In split mode, channel 0's low byte is an 8-bit timer under channel 0's run, gate and select bits, and its overflow sets flag0. Channel 0's high byte counts `tick` while run1 is 1, and its overflow sets flag1. Channel 1 keeps counting in its own mode regardless of run1 and its gate, and it never sets flag1.
- R8: With gate = 1, a channel counts only while its gate pin is high. With gate = 0, the gate pin has no effect.
- R9: With counter select = 0, a channel counts `tick` pulses. With counter select = 1, the pin is sampled on each `tick` into a two-stage synchronizer, and one count is added per 1-to-0 transition seen. Nothing is counted while `tick` is low.
- R10: Outside split mode, a channel with run = 0 holds its count.
- R11: A register write takes priority over a hardware increment or flag set in the same cycle. Writing 0 to a flag bit clears it.
- R12: Channel 1 with mode code 11 holds its count and never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle tick, one clock wide per cycle |
| ext_cnt | input | 2 | External count pins, index = channel |
| gate | input | 2 | Gate pins, index = channel |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| flag_out | output | 2 | Overflow flags, index = channel |

## Verification
Table vectors drive channel 0 through each mode code with start values chosen to land on the mode's rollover point. This separates 16-bit carry from 13-bit prescaled carry, from reload-from-high, and from the 8-bit split low byte. A ripple start such as low 0xFE and a preserved low bits [7:5] field expose a carry taken from the wrong bit. Directed runs cover the rest:

- a channel-1 run that tells nibble order apart,
- gate pin low versus high,
- pin pulses with and without `tick`,
- split mode with run1 toggled while channel 1 sits near its wrap, which shows whether flag1 has the right owner,
- same-cycle write-versus-increment collisions.

// File: rtl/dual_tmr.sv
module dual_tmr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] ext_cnt,
  input  logic [1:0] gate,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [1:0] flag_out
);
  logic [7:0] mode_q, lo0, hi0, lo1, hi1;
  logic [1:0] run_q, flg_q, sy0, sy1;
  logic [3:0] cfg0, cfg1;
  logic       split, en0, en1, ev0, ev1, evh, ovf0, set_f1;
  logic [1:0] src;
  logic [16:0] st0, st1;

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] h, input logic [7:0] l);
    logic [7:0] nh, nl;
    logic       o;
    case (m)
      2'b00: begin
        nl = {l[7:5], l[4:0] + 5'd1};
        nh = (l[4:0] == 5'h1f) ? h + 8'd1 : h;
        o  = (h == 8'hff) && (l[4:0] == 5'h1f);
      end
      2'b01: begin
        {nh, nl} = {h, l} + 16'd1;
        o = ({h, l} == 16'hffff);
      end
      2'b10: begin
        o  = (l == 8'hff);
        nl = o ? h : l + 8'd1;
        nh = h;
      end
      default: begin
        o  = (l == 8'hff);
        nl = l + 8'd1;
        nh = h;
      end
    endcase
    return {o, nh, nl};
  endfunction

  assign cfg0  = mode_q[3:0];
  assign cfg1  = mode_q[7:4];
  assign split = (cfg0[1:0] == 2'b11);

  assign src[0] = cfg0[2] ? (tick & sy1[0] & ~sy0[0]) : tick;
  assign src[1] = cfg1[2] ? (tick & sy1[1] & ~sy0[1]) : tick;

  assign en0 = run_q[0] & (~cfg0[3] | gate[0]);
  assign en1 = split | (run_q[1] & (~cfg1[3] | gate[1]));
  assign ev0 = en0 & src[0];
  assign ev1 = en1 & src[1] & (cfg1[1:0] != 2'b11);
  assign evh = split & run_q[1] & tick;

  assign st0 = step(cfg0[1:0], hi0, lo0);
  assign st1 = step(cfg1[1:0], hi1, lo1);

  assign ovf0   = ev0 & st0[16];
  assign set_f1 = split ? (evh & (hi0 == 8'hff)) : (ev1 & st1[16]);

  wire wr_mode = reg_we && (reg_addr == 3'd0);
  wire wr_ctl  = reg_we && (reg_addr == 3'd1);
  wire wr_lo0  = reg_we && (reg_addr == 3'd2);
  wire wr_hi0  = reg_we && (reg_addr == 3'd3);
  wire wr_lo1  = reg_we && (reg_addr == 3'd4);
  wire wr_hi1  = reg_we && (reg_addr == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flg_q  <= '0;
      lo0 <= '0; hi0 <= '0; lo1 <= '0; hi1 <= '0;
      sy0 <= '0; sy1 <= '0;
    end else begin
      if (tick) begin
        sy0 <= ext_cnt;
        sy1 <= sy0;
      end
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctl) begin
        run_q <= {reg_wdata[2], reg_wdata[0]};
        flg_q <= {reg_wdata[3], reg_wdata[1]};
      end else begin
        flg_q <= flg_q | {set_f1, ovf0};
      end
      if (wr_lo0)   lo0 <= reg_wdata;
      else if (ev0) lo0 <= st0[7:0];
      if (wr_hi0)            hi0 <= reg_wdata;
      else if (split && evh) hi0 <= hi0 + 8'd1;
      else if (!split && ev0) hi0 <= st0[15:8];
      if (wr_lo1)   lo1 <= reg_wdata;
      else if (ev1) lo1 <= st1[7:0];
      if (wr_hi1)   hi1 <= reg_wdata;
      else if (ev1) hi1 <= st1[15:8];
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = mode_q;
      3'd1:    reg_rdata = {4'h0, flg_q[1], run_q[1], flg_q[0], run_q[0]};
      3'd2:    reg_rdata = lo0;
      3'd3:    reg_rdata = hi0;
      3'd4:    reg_rdata = lo1;
      3'd5:    reg_rdata = hi1;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign flag_out = flg_q;
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] gate,
  input logic [2:0] reg_addr,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [1:0] flag_out,
  input logic [7:0] mode_q,
  input logic [1:0] run_q,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_we) |=> ($stable({hi0, lo0}) && $stable({hi1, lo1}))); // R9

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_out[0]) |-> ($past(tick) || $past(reg_we))); // R4

  AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] != 2'b11 && !run_q[0] && !reg_we) |=> $stable({hi0, lo0})); // R10

  AST_RELOAD_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b10 && !reg_we) |=> $stable(hi0)); // R6

  AST_CH1_MODE3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && mode_q[1:0] != 2'b11 && !reg_we) |=> ($stable({hi1, lo1}) && !$rose(flag_out[1]))); // R12

  AST_GATE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] != 2'b11 && mode_q[3] && !gate[0] && !reg_we) |=> $stable({hi0, lo0})); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2) |=> (lo0 == $past(reg_wdata))); // R11
endmodule

bind dual_tmr dual_tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .reg_addr(reg_addr),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .flag_out(flag_out), .mode_q(mode_q),
  .run_q(run_q), .lo0(lo0), .hi0(hi0), .lo1(lo1), .hi1(hi1)
);

// File: tb/dual_tmr_tb.sv
module dual_tmr_tb;
  logic       clk = 0, rst_n = 0, tick = 0, reg_we = 0;
  logic [1:0] ext_cnt = 0, gate = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] flag_out;
  int checks = 0, errors = 0;

  dual_tmr u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .ext_cnt(ext_cnt), .gate(gate),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_out(flag_out));

  always #4 clk = ~clk;

  // mode, lo, hi, tick count, expected lo, hi, flag0
  localparam logic [63:0] VEC [13] = '{
    {8'h01, 8'h00, 8'h00, 16'd5,    8'h05, 8'h00, 8'h00}, // R4
    {8'h01, 8'hfe, 8'h00, 16'd3,    8'h01, 8'h01, 8'h00}, // R4
    {8'h01, 8'hff, 8'hff, 16'd1,    8'h00, 8'h00, 8'h01}, // R4
    {8'h01, 8'h18, 8'hfc, 16'd1000, 8'h00, 8'h00, 8'h01}, // R4
    {8'h00, 8'h1e, 8'h00, 16'd2,    8'h00, 8'h01, 8'h00}, // R5
    {8'h00, 8'he0, 8'h00, 16'd33,   8'he1, 8'h01, 8'h00}, // R5
    {8'h00, 8'h1f, 8'hff, 16'd1,    8'h00, 8'h00, 8'h01}, // R5
    {8'h00, 8'hff, 8'hff, 16'd1,    8'he0, 8'h00, 8'h01}, // R5
    {8'h02, 8'hfe, 8'h80, 16'd3,    8'h81, 8'h80, 8'h01}, // R6
    {8'h02, 8'hf0, 8'hf0, 16'd16,   8'hf0, 8'hf0, 8'h01}, // R6
    {8'h02, 8'h00, 8'h05, 16'd4,    8'h04, 8'h05, 8'h00}, // R6
    {8'h03, 8'hfd, 8'h07, 16'd2,    8'hff, 8'h07, 8'h00}, // R7
    {8'h03, 8'hff, 8'h07, 16'd1,    8'h00, 8'h07, 8'h01}  // R7
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] l, h;
    rd(a, l); rd(a + 3'd1, h); v = {h, l};
  endtask

  logic [7:0] r;
  logic [15:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R2 reset state and map
    for (int a = 0; a < 8; a++) begin rd(a[2:0], r); chk("R1", {8'h0, r}, 16'h0); end
    chk("R1 flags", {14'h0, flag_out}, 16'h0);

    for (int i = 0; i < 13; i++) begin
      wr(1, 8'h00); wr(0, VEC[i][63:56]); wr(2, VEC[i][55:48]); wr(3, VEC[i][47:40]);
      wr(1, 8'h01);
      ticks(int'(VEC[i][39:24]));
      rd(2, r); chk($sformatf("R4-7 vec%0d lo", i), {8'h0, r}, {8'h0, VEC[i][23:16]});
      rd(3, r); chk($sformatf("R4-7 vec%0d hi", i), {8'h0, r}, {8'h0, VEC[i][15:8]});
      rd(1, r); chk($sformatf("R2 vec%0d flag0", i), {15'h0, r[1]}, {15'h0, VEC[i][0]});
    end

    // R3: high nibble drives channel 1 (16-bit), low nibble channel 0 (13-bit)
    wr(1, 8'h00); wr(0, 8'h10); wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'hff); wr(5, 8'h00);
    wr(1, 8'h04); ticks(1);
    rd16(4, v); chk("R3 ch1 16-bit", v, 16'h0100);
    rd16(2, v); chk("R3 ch0 idle", v, 16'h0000);
    rd(0, r); chk("R2 mode readback", {8'h0, r}, 16'h0010);

    // R8 gate
    wr(1, 8'h00); wr(0, 8'h09); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h01);
    gate = 2'b00; ticks(5);
    rd16(2, v); chk("R8 gate low", v, 16'h0000);
    gate = 2'b01; ticks(5);
    rd16(2, v); chk("R8 gate high", v, 16'h0005);
    wr(0, 8'h01); gate = 2'b00; ticks(2);
    rd16(2, v); chk("R8 gate ignored", v, 16'h0007);

    // R9 external pin counting
    wr(1, 8'h00); wr(0, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h01);
    @(negedge clk); tick = 1;
    for (int k = 0; k < 3; k++) begin
      ext_cnt[0] = 1; repeat (4) @(negedge clk);
      ext_cnt[0] = 0; repeat (4) @(negedge clk);
    end
    ext_cnt[0] = 1; repeat (4) @(negedge clk);
    tick = 0;
    rd16(2, v); chk("R9 three edges", v, 16'h0003);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ext_cnt[0] = 0; @(negedge clk); ext_cnt[0] = 1;
    end
    rd16(2, v); chk("R9 no tick", v, 16'h0003);

    // R10 run off
    wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'h34); wr(3, 8'h12); ticks(10);
    rd16(2, v); chk("R10 run off", v, 16'h1234);

    // R7 split mode
    wr(1, 8'h00); wr(0, 8'h13); wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'hff); wr(5, 8'hff);
    wr(1, 8'h04); ticks(3);
    rd(3, r); chk("R7 hi0 counts", {8'h0, r}, 16'h0003);
    rd(2, r); chk("R7 lo0 held", {8'h0, r}, 16'h0000);
    rd16(4, v); chk("R7 ch1 runs", v, 16'h0002);
    chk("R7 ch1 no flag", {14'h0, flag_out}, 16'h0);
    wr(1, 8'h00); ticks(2);
    rd(3, r); chk("R7 hi0 stopped", {8'h0, r}, 16'h0003);
    rd16(4, v); chk("R7 ch1 unstoppable", v, 16'h0004);
    wr(3, 8'hfe); wr(1, 8'h04); ticks(2);
    rd(3, r); chk("R7 hi0 wrap", {8'h0, r}, 16'h0000);
    chk("R7 flag1 from hi0", {14'h0, flag_out}, 16'h0002);

    // R12 channel 1 mode 11
    wr(1, 8'h00); wr(0, 8'h30); wr(4, 8'h12); wr(5, 8'h34); wr(1, 8'h04); ticks(5);
    rd16(4, v); chk("R12 ch1 held", v, 16'h3412);
    chk("R12 no flag", {14'h0, flag_out}, 16'h0);

    // R11 write priority and flag clear
    wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'hff); wr(3, 8'hff); wr(1, 8'h01); ticks(1);
    chk("R11 flag set", {14'h0, flag_out}, 16'h0001);
    wr(1, 8'h01);
    chk("R11 flag cleared", {14'h0, flag_out}, 16'h0000);
    @(negedge clk); tick = 1; reg_we = 1; reg_addr = 2; reg_wdata = 8'h40;
    @(negedge clk); tick = 0; reg_we = 0;
    rd16(2, v); chk("R11 write beats count", v, 16'h0040);
    wr(2, 8'hff); wr(3, 8'hff);
    @(negedge clk); tick = 1; reg_we = 1; reg_addr = 1; reg_wdata = 8'h01;
    @(negedge clk); tick = 0; reg_we = 0;
    chk("R11 write beats flag", {14'h0, flag_out}, 16'h0000);
    rd16(2, v); chk("R11 count wrapped", v, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule